// File: doc/BRIEF.md
# Lockable Clock-Multiplier Configuration Registers

This block is the software-visible home of a clock multiplier's settings: the upper part of the multiply factor, the reference divider, a 12-bit loop bandwidth adjustment and a saturation enable. It also holds a two-bit reset-isolation control for two groups of serial link lanes. Software reads it freely. It may change the settings only after it writes two fixed key words, in order, to two key registers. A wrong key value closes the block again, and so does a warm reset.

All stored settings survive warm reset and clear only on power-on reset. The low six multiplier bits come from a separate controller input. The active configuration driven to the multiplier is a snapshot. It is taken only on the controller's GO pulse, and it joins this block's upper bits with the controller's lower bits into one 13-bit factor. A flag reports when the snapshot's bandwidth value does not match the factor. The lane reset outputs let isolated lane groups ride through warm resets.

The bus is a plain one-cycle command port with no back-pressure. A command is accepted in every cycle in which `cmd_valid_i` is high. A read returns its data on `rsp_rdata_o` with `rsp_valid_o` high for exactly the next cycle.

Top module: `pll_cfg_regs`

## Requirements
- R1: After power-on reset, word 0 reads 0x0500_0000, words 1 and 2 read zero, the block is locked, the active bandwidth output is 0x005 with multiplier and divider 0, the bandwidth flag is high, and both lane reset outputs are low once reset has been released for two cycles.
- R2: A write of KEY0_VAL to word 3 followed by a write of KEY1_VAL to word 4 unlocks writes to words 0, 1 and 2 from the next cycle on. The key words always read zero.
- R3: While the block is locked, or after only the first key has been written, writes to words 0 to 2 change nothing. Writing any value other than its own key to word 3 or word 4 locks the block again.
- R4: Word 0 holds bandwidth bits [7:0] at bits 31:24, multiplier bits [12:6] at bits 18:12 and the divider (minus one) at bits 5:0. Its other bits read zero and ignore writes.
- R5: Word 1 holds the saturation enable at bit 6 and bandwidth bits [11:8] at bits 3:0. Word 2 holds lane isolation at bits 1:0. Every other bit of both words reads zero and ignores writes.
- R6: The multiplier, divider, bandwidth and saturation outputs change only in the cycle after GO. They then show the register contents from before that edge, with the multiplier equal to {word0[18:12], ctl_mult_lo_i}.
- R7: `bw_err_o` is high exactly when the active bandwidth value differs from ((active multiplier + 1) >> 1) - 1, computed in 14 bits.
- R8: Warm reset leaves words 0 to 2 and the active outputs unchanged and locks the block.
- R9: Lane reset output g is high during power-on reset. Otherwise it follows (warm_rst_i AND NOT isolation bit g) delayed by two clock edges.
- R10: A read command gives `rsp_valid_o` high for exactly the next cycle, with the word's data. A write command gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_i | input | 1 | Warm chip reset, active high, synchronous |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 3 | Word index (0 to 4) |
| cmd_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| ctl_mult_lo_i | input | 6 | Multiplier bits [5:0] from the controller |
| go_i | input | 1 | Snapshot strobe from the controller |
| pll_mult_o | output | 13 | Active multiplier (factor minus one) |
| pll_div_o | output | 6 | Active reference divider (minus one) |
| pll_bwadj_o | output | 12 | Active bandwidth adjust |
| pll_sat_en_o | output | 1 | Active saturation enable |
| bw_err_o | output | 1 | Bandwidth value inconsistent with multiplier |
| lane_rst_o | output | LANE_GRPS | Per-group lane reset, active high |

## Verification
Two collisions need care. The first is a GO pulse in the same cycle as a bus write to word 0. The bench drives both on one edge, then checks that the active multiplier and divider come from the old register contents while a readback shows the new word. The second is a warm reset on top of a configured, unlocked block. The bench checks that the settings and snapshot are kept, that a later write is refused because the lock has closed, and that the lane outputs rise after two edges only for groups without isolation.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int MULT_W    = 13;
  localparam int MULT_LO_W = 6;
  localparam int MULT_HI_W = MULT_W - MULT_LO_W;
  localparam int DIV_W     = 6;
  localparam int BW_W      = 12;
  localparam int BW_LO_W   = 8;
  localparam int BW_HI_W   = BW_W - BW_LO_W;
  localparam logic [BW_W-1:0] BW_RESET = 12'h005;

  localparam int W0_BW_LSB  = 24;
  localparam int W0_MH_LSB  = 12;
  localparam int W0_DIV_LSB = 0;
  localparam int W1_SAT_BIT = 6;
  localparam int W1_BWH_LSB = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_CTL0 = 3'd0,
    A_CTL1 = 3'd1,
    A_ISO  = 3'd2,
    A_KEY0 = 3'd3,
    A_KEY1 = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_st_e;

  function automatic logic [DATA_W-1:0] pack_w0(
      input logic [BW_LO_W-1:0] bw_lo,
      input logic [MULT_HI_W-1:0] mhi,
      input logic [DIV_W-1:0] dv);
    logic [DATA_W-1:0] w;
    w = '0;
    w[W0_BW_LSB +: BW_LO_W]   = bw_lo;
    w[W0_MH_LSB +: MULT_HI_W] = mhi;
    w[W0_DIV_LSB +: DIV_W]    = dv;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_w1(
      input logic sat, input logic [BW_HI_W-1:0] bw_hi);
    logic [DATA_W-1:0] w;
    w = '0;
    w[W1_SAT_BIT]             = sat;
    w[W1_BWH_LSB +: BW_HI_W]  = bw_hi;
    return w;
  endfunction
endpackage

// File: rtl/pll_key_lock.sv
module pll_key_lock
  import pll_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY0_VAL = 32'h5AC3_17E9,
  parameter logic [DATA_W-1:0] KEY1_VAL = 32'hC0DE_4B21
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_i,
  input  logic              key_wr0_i,
  input  logic              key_wr1_i,
  input  logic [DATA_W-1:0] key_data_i,
  output logic              unlocked_o
);
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr0_i) begin
      st_d = (key_data_i == KEY0_VAL) ? LK_HALF : LK_SHUT;
    end else if (key_wr1_i) begin
      if (key_data_i != KEY1_VAL)  st_d = LK_SHUT;
      else if (st_q == LK_HALF)    st_d = LK_OPEN;
      else if (st_q == LK_OPEN)    st_d = LK_OPEN;
      else                         st_d = LK_SHUT;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          st_q <= LK_SHUT;
    else if (warm_rst_i) st_q <= LK_SHUT;
    else                 st_q <= st_d;
  end

  assign unlocked_o = (st_q == LK_OPEN);

  AST_BAD_KEY0_LOCKS: assert property (@(posedge clk) disable iff (!por_n)
    (key_wr0_i && key_data_i != KEY0_VAL) |=> !unlocked_o); // R3
  AST_BAD_KEY1_LOCKS: assert property (@(posedge clk) disable iff (!por_n)
    (key_wr1_i && key_data_i != KEY1_VAL) |=> !unlocked_o); // R3
  AST_OPEN_AFTER_KEY1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(unlocked_o) |-> $past(key_wr1_i)); // R2
  AST_WARM_RELOCKS: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst_i |=> !unlocked_o); // R8
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int LANE_GRPS = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 unlocked_i,
  input  logic                 wr_w0_i,
  input  logic                 wr_w1_i,
  input  logic                 wr_iso_i,
  input  logic [BW_LO_W-1:0]   d_bw_lo_i,
  input  logic [MULT_HI_W-1:0] d_mhi_i,
  input  logic [DIV_W-1:0]     d_div_i,
  input  logic                 d_sat_i,
  input  logic [BW_HI_W-1:0]   d_bw_hi_i,
  input  logic [LANE_GRPS-1:0] d_iso_i,
  output logic [BW_W-1:0]      bw_o,
  output logic [MULT_HI_W-1:0] mhi_o,
  output logic [DIV_W-1:0]     div_o,
  output logic                 sat_o,
  output logic [LANE_GRPS-1:0] iso_o
);
  logic [BW_LO_W-1:0] bw_lo_q;
  logic [BW_HI_W-1:0] bw_hi_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bw_lo_q <= BW_RESET[BW_LO_W-1:0];
      mhi_o   <= '0;
      div_o   <= '0;
    end else if (wr_w0_i && unlocked_i) begin
      bw_lo_q <= d_bw_lo_i;
      mhi_o   <= d_mhi_i;
      div_o   <= d_div_i;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bw_hi_q <= BW_RESET[BW_W-1:BW_LO_W];
      sat_o   <= 1'b0;
    end else if (wr_w1_i && unlocked_i) begin
      bw_hi_q <= d_bw_hi_i;
      sat_o   <= d_sat_i;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       iso_o <= '0;
    else if (wr_iso_i && unlocked_i)  iso_o <= d_iso_i;
  end

  assign bw_o = {bw_hi_q, bw_lo_q};

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    (!unlocked_i && (wr_w0_i || wr_w1_i || wr_iso_i)) |=>
      ($stable(bw_o) && $stable(mhi_o) && $stable(div_o) && $stable(sat_o) && $stable(iso_o))); // R3
endmodule

// File: rtl/pll_go_capture.sv
module pll_go_capture
  import pll_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 go_i,
  input  logic [MULT_HI_W-1:0] mhi_i,
  input  logic [MULT_LO_W-1:0] mlo_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [BW_W-1:0]      bw_i,
  input  logic                 sat_i,
  output logic [MULT_W-1:0]    mult_o,
  output logic [DIV_W-1:0]     div_o,
  output logic [BW_W-1:0]      bw_o,
  output logic                 sat_o,
  output logic                 bw_err_o
);
  localparam int CW = MULT_W + 1;

  logic [CW-1:0] half_w, want_w;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mult_o <= '0;
      div_o  <= '0;
      bw_o   <= BW_RESET;
      sat_o  <= 1'b0;
    end else if (go_i) begin
      mult_o <= {mhi_i, mlo_i};
      div_o  <= div_i;
      bw_o   <= bw_i;
      sat_o  <= sat_i;
    end
  end

  always_comb begin
    half_w   = ({1'b0, mult_o} + CW'(1)) >> 1;
    want_w   = half_w - CW'(1);
    bw_err_o = (want_w != CW'(bw_o));
  end

  AST_HOLD_WITHOUT_GO: assert property (@(posedge clk) disable iff (!por_n)
    !go_i |=> ($stable(mult_o) && $stable(div_o) && $stable(bw_o) && $stable(sat_o))); // R6
  AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!por_n)
    !go_i |=> $stable(bw_err_o)); // R7
endmodule

// File: rtl/pll_lane_rst.sv
module pll_lane_rst #(
  parameter int LANE_GRPS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 warm_rst_i,
  input  logic [LANE_GRPS-1:0] iso_i,
  output logic [LANE_GRPS-1:0] lane_rst_o
);
  for (genvar g = 0; g < LANE_GRPS; g++) begin : g_grp
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sh_q <= '1;
      else        sh_q <= {sh_q[SYNC_STAGES-2:0], warm_rst_i & ~iso_i[g]};
    end
    assign lane_rst_o[g] = sh_q[SYNC_STAGES-1];
  end

  initial begin
    AST_STAGES_MIN: assert (SYNC_STAGES >= 2); // R9
  end
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter logic [31:0] KEY0_VAL    = 32'h5AC3_17E9,
  parameter logic [31:0] KEY1_VAL    = 32'hC0DE_4B21,
  parameter int          LANE_GRPS   = 2,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 warm_rst_i,
  input  logic                 cmd_valid_i,
  input  logic                 cmd_write_i,
  input  logic [2:0]           cmd_addr_i,
  input  logic [31:0]          cmd_wdata_i,
  output logic                 rsp_valid_o,
  output logic [31:0]          rsp_rdata_o,
  input  logic [5:0]           ctl_mult_lo_i,
  input  logic                 go_i,
  output logic [12:0]          pll_mult_o,
  output logic [5:0]           pll_div_o,
  output logic [11:0]          pll_bwadj_o,
  output logic                 pll_sat_en_o,
  output logic                 bw_err_o,
  output logic [LANE_GRPS-1:0] lane_rst_o
);
  logic wr, rd, unlocked;
  logic [BW_W-1:0]      r_bw;
  logic [MULT_HI_W-1:0] r_mhi;
  logic [DIV_W-1:0]     r_div;
  logic                 r_sat;
  logic [LANE_GRPS-1:0] r_iso;
  logic [DATA_W-1:0]    rd_mux;

  assign wr = cmd_valid_i && cmd_write_i;
  assign rd = cmd_valid_i && !cmd_write_i;

  pll_key_lock #(.KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)) u_lock (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_i (warm_rst_i),
    .key_wr0_i  (wr && cmd_addr_i == A_KEY0),
    .key_wr1_i  (wr && cmd_addr_i == A_KEY1),
    .key_data_i (cmd_wdata_i),
    .unlocked_o (unlocked)
  );

  pll_cfg_bank #(.LANE_GRPS(LANE_GRPS)) u_bank (
    .clk        (clk),
    .por_n      (por_n),
    .unlocked_i (unlocked),
    .wr_w0_i    (wr && cmd_addr_i == A_CTL0),
    .wr_w1_i    (wr && cmd_addr_i == A_CTL1),
    .wr_iso_i   (wr && cmd_addr_i == A_ISO),
    .d_bw_lo_i  (cmd_wdata_i[W0_BW_LSB +: BW_LO_W]),
    .d_mhi_i    (cmd_wdata_i[W0_MH_LSB +: MULT_HI_W]),
    .d_div_i    (cmd_wdata_i[W0_DIV_LSB +: DIV_W]),
    .d_sat_i    (cmd_wdata_i[W1_SAT_BIT]),
    .d_bw_hi_i  (cmd_wdata_i[W1_BWH_LSB +: BW_HI_W]),
    .d_iso_i    (cmd_wdata_i[LANE_GRPS-1:0]),
    .bw_o       (r_bw),
    .mhi_o      (r_mhi),
    .div_o      (r_div),
    .sat_o      (r_sat),
    .iso_o      (r_iso)
  );

  pll_go_capture u_go (
    .clk      (clk),
    .por_n    (por_n),
    .go_i     (go_i),
    .mhi_i    (r_mhi),
    .mlo_i    (ctl_mult_lo_i),
    .div_i    (r_div),
    .bw_i     (r_bw),
    .sat_i    (r_sat),
    .mult_o   (pll_mult_o),
    .div_o    (pll_div_o),
    .bw_o     (pll_bwadj_o),
    .sat_o    (pll_sat_en_o),
    .bw_err_o (bw_err_o)
  );

  pll_lane_rst #(.LANE_GRPS(LANE_GRPS), .SYNC_STAGES(SYNC_STAGES)) u_lane (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_i (warm_rst_i),
    .iso_i      (r_iso),
    .lane_rst_o (lane_rst_o)
  );

  always_comb begin
    rd_mux = '0;
    case (cmd_addr_i)
      A_CTL0:  rd_mux = pack_w0(r_bw[BW_LO_W-1:0], r_mhi, r_div);
      A_CTL1:  rd_mux = pack_w1(r_sat, r_bw[BW_W-1:BW_LO_W]);
      A_ISO:   rd_mux = DATA_W'(r_iso);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rd_mux;
    end
  end

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!por_n)
    rd |=> rsp_valid_o); // R10
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!por_n)
    !rd |=> !rsp_valid_o); // R10
endmodule

// File: tb/sim_pll_cfg_regs.sv
module sim_pll_cfg_regs;
  localparam logic [31:0] K0 = 32'h5AC3_17E9;
  localparam logic [31:0] K1 = 32'hC0DE_4B21;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic warm = 1'b0;
  logic cv = 1'b0, cw = 1'b0;
  logic [2:0] ca = '0;
  logic [31:0] cd = '0;
  logic rv;
  logic [31:0] rdat;
  logic [5:0] mlo = '0;
  logic go = 1'b0;
  logic [12:0] mult;
  logic [5:0] dv;
  logic [11:0] bw;
  logic sat, berr;
  logic [1:0] lane;

  int n_chk = 0, n_bad = 0;
  logic [31:0] tmp;

  always #4 clk = ~clk;

  pll_cfg_regs u0 (
    .clk(clk), .por_n(por_n), .warm_rst_i(warm),
    .cmd_valid_i(cv), .cmd_write_i(cw), .cmd_addr_i(ca), .cmd_wdata_i(cd),
    .rsp_valid_o(rv), .rsp_rdata_o(rdat),
    .ctl_mult_lo_i(mlo), .go_i(go),
    .pll_mult_o(mult), .pll_div_o(dv), .pll_bwadj_o(bw), .pll_sat_en_o(sat),
    .bw_err_o(berr), .lane_rst_o(lane)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cv = 1'b1; cw = 1'b1; ca = a; cd = d;
    @(negedge clk); cv = 1'b0; cw = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cv = 1'b1; cw = 1'b0; ca = a;
    @(negedge clk); cv = 1'b0;
    chk("R10 rsp_valid", 32'(rv), 32'd1);
    d = rdat;
  endtask

  task automatic unlock();
    wr(3'd3, K0); wr(3'd4, K1);
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic t_reset();
    rd(3'd0, tmp); chk("R1 word0", tmp, 32'h0500_0000);
    rd(3'd1, tmp); chk("R1 word1", tmp, 32'h0);
    rd(3'd2, tmp); chk("R1 word2", tmp, 32'h0);
    chk("R1 bw out", 32'(bw), 32'h005);
    chk("R1 mult out", 32'(mult), 32'h0);
    chk("R1 flag", 32'(berr), 32'd1);
    chk("R1 lanes", 32'(lane), 32'h0);
    @(negedge clk);
    chk("R10 no rsp when idle", 32'(rv), 32'd0);
  endtask

  task automatic t_locked();
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, tmp); chk("R3 locked write", tmp, 32'h0500_0000);
    wr(3'd3, K0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, tmp); chk("R3 half unlock", tmp, 32'h0);
  endtask

  task automatic t_unlock_rw();
    unlock();
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, tmp); chk("R4 word0 fields", tmp, 32'hFF07_F03F);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, tmp); chk("R5 word1 fields", tmp, 32'h0000_004F);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, tmp); chk("R5 iso fields", tmp, 32'h3);
    rd(3'd3, tmp); chk("R2 key0 reads zero", tmp, 32'h0);
    rd(3'd4, tmp); chk("R2 key1 reads zero", tmp, 32'h0);
    wr(3'd2, 32'h0);
    rd(3'd2, tmp); chk("R2 open writes", tmp, 32'h0);
  endtask

  task automatic t_relock();
    wr(3'd4, 32'h1234_5678);
    wr(3'd1, 32'h0);
    rd(3'd1, tmp); chk("R3 bad key1 relocks", tmp, 32'h4F);
    unlock();
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h0);
    rd(3'd1, tmp); chk("R3 bad key0 relocks", tmp, 32'h4F);
  endtask

  task automatic t_go();
    unlock();
    wr(3'd0, 32'h0500_0003);
    wr(3'd1, 32'h0);
    mlo = 6'd11;
    @(negedge clk);
    chk("R6 no change before GO", 32'(mult), 32'h0);
    pulse_go();
    chk("R6 mult", 32'(mult), 32'd11);
    chk("R6 div", 32'(dv), 32'd3);
    chk("R6 bw", 32'(bw), 32'h005);
    chk("R7 consistent", 32'(berr), 32'd0);
    mlo = 6'd20;
    repeat (3) @(negedge clk);
    chk("R6 low bits need GO", 32'(mult), 32'd11);
  endtask

  task automatic t_bw();
    mlo = 6'd11;
    wr(3'd0, 32'h2500_1003);
    pulse_go();
    chk("R6 split multiplier", 32'(mult), 32'd75);
    chk("R7 ok at 75/0x25", 32'(berr), 32'd0);
    wr(3'd1, 32'h41);
    pulse_go();
    chk("R6 bw high bits", 32'(bw), 32'h125);
    chk("R6 sat", 32'(sat), 32'd1);
    chk("R7 mismatch", 32'(berr), 32'd1);
    wr(3'd1, 32'h0);
    pulse_go();
    chk("R7 restored", 32'(berr), 32'd0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    cv = 1'b1; cw = 1'b1; ca = 3'd0; cd = 32'h0102_3004; go = 1'b1;
    @(negedge clk);
    cv = 1'b0; cw = 1'b0; go = 1'b0;
    chk("R6 GO sees old mult", 32'(mult), 32'd75);
    chk("R6 GO sees old div", 32'(dv), 32'd3);
    rd(3'd0, tmp); chk("R4 write landed", tmp, 32'h0102_3004);
  endtask

  task automatic t_warm();
    @(negedge clk); warm = 1'b1;
    @(negedge clk); warm = 1'b0;
    rd(3'd0, tmp); chk("R8 word0 kept", tmp, 32'h0102_3004);
    chk("R8 active kept", 32'(mult), 32'd75);
    wr(3'd0, 32'h0);
    rd(3'd0, tmp); chk("R8 relocked", tmp, 32'h0102_3004);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_lane();
    unlock();
    wr(3'd2, 32'h1);
    @(negedge clk); warm = 1'b1;
    @(negedge clk); chk("R9 one edge", 32'(lane), 32'h0);
    @(negedge clk); chk("R9 group1 resets", 32'(lane), 32'h2);
    @(negedge clk); warm = 1'b0;
    @(negedge clk); chk("R9 hold", 32'(lane), 32'h2);
    @(negedge clk); chk("R9 release", 32'(lane), 32'h0);
    unlock();
    wr(3'd2, 32'h3);
    @(negedge clk); warm = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 both isolated", 32'(lane), 32'h0);
    warm = 1'b0;
    @(negedge clk);
    por_n = 1'b0;
    #1 chk("R9 por forces", 32'(lane), 32'h3);
    @(negedge clk); por_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd2, tmp); chk("R1 por clears iso", tmp, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_locked();
    t_unlock_rw();
    t_relock();
    t_go();
    t_bw();
    t_collide();
    t_warm();
    t_lane();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule